// File: doc/BRIEF.md
# DRAM Strobe Timing Checker

A passive observer for an asynchronous DRAM bus. It samples the row strobe, column strobe and write enable on a fast reference clock. It measures how long each level lasts in clock ticks and raises one sticky flag for each timing or protocol rule that the bus breaks. It drives nothing on the bus and holds no memory contents.

Cycles are classified by the order of the strobe edges. If the column strobe is already low when the row strobe falls, the cycle is a column-before-row refresh, and the checker counts it. A column strobe that falls while the row strobe is low in any other cycle is a normal access. The checker also tracks the power-up sequence: a minimum number of refreshes and a minimum delay from reset must come before the first access. It also checks that enough refreshes land in each fixed window period, with the window restarting every period.

Every limit is a parameter in reference-clock ticks. A level held for L sampled clocks is measured as L ticks. A flag stays set until `clr_i` is pulsed.

Top module: `dram_strobe_monitor`

## Requirements
- R1: After reset, all bits of `viol_o` are 0 and `refresh_count_o` is 0.
- R2: Bit 0 of `viol_o` is set when the row strobe falls after a high time shorter than T_RP ticks. It applies only once the row strobe has risen at least once since reset.
- R3: Bit 1 is set when a row-strobe low pulse is shorter than T_RAS ticks. Bit 2 is set when the row strobe stays low longer than T_RAS_MAX ticks. In a page cycle (two or more column accesses under one row-strobe low) the bit 2 limit is T_RASP_MAX instead.
- R4: A row-strobe fall while the column strobe is low is a refresh. Each refresh adds exactly one to `refresh_count_o`. Row-only cycles and normal accesses leave the count unchanged.
- R5: In a refresh, bit 3 is set when the column strobe was low for fewer than T_CSR ticks before the row strobe fell. A simultaneous fall counts as 0 ticks. Bit 4 is set when the column strobe rises fewer than T_CHR ticks after the row-strobe fall.
- R6: Bit 5 is set at the first normal access after reset if fewer than INIT_REFS refreshes came before it, or if it starts fewer than T_INIT ticks after reset.
- R7: Bit 6 is set at the end of each REF_WINDOW-tick period, counted from reset, in which fewer than REF_MIN refreshes occurred.
- R8: Bit 7 is set when the first column-strobe fall of a normal access comes fewer than T_RCD ticks after the row-strobe fall.
- R9: Bit 8 is set when a normal-access column-strobe low pulse is shorter than T_CAS ticks.
- R10: Bit 9 is set when write enable falls while the column strobe of a normal access is already low. Only writes with write enable low at the column-strobe fall are allowed.
- R11: Set bits of `viol_o` stay set until `clr_i` is high for one clock, which returns them to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Clears all sticky violation flags |
| ras_n_i | input | 1 | Observed row strobe, active low |
| cas_n_i | input | 1 | Observed column strobe, active low |
| we_n_i | input | 1 | Observed write enable, active low |
| viol_o | output | 10 | Sticky violation flags, one per rule |
| refresh_count_o | output | REF_CNT_W | Number of refresh cycles seen since reset |

## Verification
Each duration rule is swept across its threshold, from two ticks below the limit to one tick above. This separates an off-by-one in the comparison from a measurement error in the level timers.

Refreshes with zero, short and ample column-strobe lead are set against normal accesses and row-only cycles. This shows that edge order alone selects the rule set and the refresh counter.

Early, late and no-write accesses separate the write-enable rule from the column-strobe timing. Page cycles just under and over both low-time limits show that the second column access switches the limit.

The power-up rule is tried with too few refreshes, with too little delay, and with both satisfied. Two consecutive windows, one with enough refreshes and one short, exercise the density rule.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
  localparam int NUM_RULES      = 10;
  localparam int RULE_RP        = 0;
  localparam int RULE_RAS_MIN   = 1;
  localparam int RULE_RAS_MAX   = 2;
  localparam int RULE_CBR_LEAD  = 3;
  localparam int RULE_CBR_HOLD  = 4;
  localparam int RULE_INIT      = 5;
  localparam int RULE_DENSITY   = 6;
  localparam int RULE_RCD       = 7;
  localparam int RULE_CAS_MIN   = 8;
  localparam int RULE_LATE_WR   = 9;

  localparam int SIG_RAS = 0;
  localparam int SIG_CAS = 1;
  localparam int SIG_WE  = 2;
  localparam int NUM_SIG = 3;
endpackage

// File: rtl/dsm_edge_det.sv
module dsm_edge_det #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] chg
);
  logic [W-1:0] prev_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl[i]    <= 1'b1;
        prev_q[i] <= 1'b1;
      end else begin
        lvl[i]    <= din[i];
        prev_q[i] <= lvl[i];
      end
    end
    assign chg[i] = lvl[i] ^ prev_q[i];
  end
endmodule

// File: rtl/dsm_sat_timer.sv
module dsm_sat_timer #(
  parameter int MAX = 100,
  parameter int W   = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] LIM = W'(MAX);
  logic [W-1:0] cnt_d;

  always_comb begin
    if (restart)         cnt_d = W'(1);
    else if (cnt == LIM) cnt_d = cnt;
    else                 cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  // R3
  sat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= LIM);
endmodule

// File: rtl/dsm_refresh_window.sv
module dsm_refresh_window #(
  parameter int WINDOW   = 1000,
  parameter int MIN_REFS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  output logic short_o
);
  localparam int TW = $clog2(WINDOW + 1);
  localparam int CW = $clog2(MIN_REFS + 1);
  localparam logic [TW-1:0] LAST = TW'(WINDOW - 1);
  localparam logic [CW-1:0] NEED = CW'(MIN_REFS);

  logic [TW-1:0] tick_q, tick_d;
  logic [CW-1:0] refs_q, refs_d, refs_eff;
  logic          wrap;

  always_comb begin
    wrap     = (tick_q == LAST);
    refs_eff = (evt && refs_q != NEED) ? refs_q + 1'b1 : refs_q;
    tick_d   = wrap ? '0 : tick_q + 1'b1;
    refs_d   = wrap ? '0 : refs_eff;
    short_o  = wrap && (refs_eff < NEED);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      refs_q <= '0;
    end else begin
      tick_q <= tick_d;
      refs_q <= refs_d;
    end
  end

  // R7
  win_range_chk: assert property (@(posedge clk) disable iff (!rst_n) tick_q <= LAST);
  // R7
  refs_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) refs_q <= NEED);
endmodule

// File: rtl/dram_strobe_monitor.sv
module dram_strobe_monitor
  import dsm_pkg::*;
#(
  parameter int T_RP        = 30,
  parameter int T_RAS       = 50,
  parameter int T_RAS_MAX   = 10000,
  parameter int T_RASP_MAX  = 200000,
  parameter int T_CSR       = 5,
  parameter int T_CHR       = 10,
  parameter int T_RCD       = 20,
  parameter int T_CAS       = 8,
  parameter int T_INIT      = 200000,
  parameter int INIT_REFS   = 8,
  parameter int REF_WINDOW  = 16000000,
  parameter int REF_MIN     = 1024,
  parameter int REF_CNT_W   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_i,
  input  logic                 ras_n_i,
  input  logic                 cas_n_i,
  input  logic                 we_n_i,
  output logic [NUM_RULES-1:0] viol_o,
  output logic [REF_CNT_W-1:0] refresh_count_o
);
  localparam int RAS_LIM = (T_RASP_MAX > T_RAS_MAX ? T_RASP_MAX : T_RAS_MAX) + 1;
  localparam int RW      = $clog2(RAS_LIM + 1);
  localparam int CAS_LIM = (T_CSR > T_CAS ? T_CSR : T_CAS) + 1;
  localparam int CW      = $clog2(CAS_LIM + 1);
  localparam int IW      = $clog2(T_INIT + 1);
  localparam int NW      = $clog2(INIT_REFS + 1);

  logic [NUM_SIG-1:0] lvl, chg;
  logic s_ras, s_cas, ras_fell, ras_rose, cas_fell, cas_rose, we_fell;
  logic [RW-1:0] ras_t;
  logic [CW-1:0] cas_t, cas_lead;
  logic [IW-1:0] init_t;
  logic          win_short;

  logic cbr_q, cbr_d, acc_q, acc_d, page_q, page_d, hit_q, hit_d;
  logic rose_seen_q, rose_seen_d, first_q, first_d;
  logic [NW-1:0] init_refs_q, init_refs_d;
  logic [REF_CNT_W-1:0] ref_cnt_q, ref_cnt_d;
  logic [NUM_RULES-1:0] viol_q, viol_d, new_v;
  logic cbr_start, normal_cas;
  logic [RW-1:0] ras_limit;

  dsm_edge_det #(.W(NUM_SIG)) u_edges (
    .clk(clk), .rst_n(rst_n), .din({we_n_i, cas_n_i, ras_n_i}), .lvl(lvl), .chg(chg)
  );

  assign s_ras    = lvl[SIG_RAS];
  assign s_cas    = lvl[SIG_CAS];
  assign ras_fell = chg[SIG_RAS] & ~s_ras;
  assign ras_rose = chg[SIG_RAS] &  s_ras;
  assign cas_fell = chg[SIG_CAS] & ~s_cas;
  assign cas_rose = chg[SIG_CAS] &  s_cas;
  assign we_fell  = chg[SIG_WE]  & ~lvl[SIG_WE];

  dsm_sat_timer #(.MAX(RAS_LIM), .W(RW)) u_ras_timer (
    .clk(clk), .rst_n(rst_n), .restart(chg[SIG_RAS]), .cnt(ras_t)
  );
  dsm_sat_timer #(.MAX(CAS_LIM), .W(CW)) u_cas_timer (
    .clk(clk), .rst_n(rst_n), .restart(chg[SIG_CAS]), .cnt(cas_t)
  );
  dsm_sat_timer #(.MAX(T_INIT), .W(IW)) u_init_timer (
    .clk(clk), .rst_n(rst_n), .restart(1'b0), .cnt(init_t)
  );
  dsm_refresh_window #(.WINDOW(REF_WINDOW), .MIN_REFS(REF_MIN)) u_window (
    .clk(clk), .rst_n(rst_n), .evt(cbr_start), .short_o(win_short)
  );

  always_comb begin
    cbr_start  = ras_fell && !s_cas;
    normal_cas = cas_fell && !s_ras && !ras_fell && !cbr_q;
    cas_lead   = cas_fell ? '0 : cas_t;
    ras_limit  = page_q ? RW'(T_RASP_MAX) : RW'(T_RAS_MAX);

    cbr_d       = ras_fell ? cbr_start : (ras_rose ? 1'b0 : cbr_q);
    acc_d       = normal_cas ? 1'b1 : (cas_rose ? 1'b0 : acc_q);
    hit_d       = ras_fell ? 1'b0 : (normal_cas ? 1'b1 : hit_q);
    page_d      = ras_fell ? 1'b0 : ((normal_cas && hit_q) ? 1'b1 : page_q);
    rose_seen_d = rose_seen_q | ras_rose;
    first_d     = first_q | normal_cas;
    init_refs_d = (cbr_start && init_refs_q != NW'(INIT_REFS)) ? init_refs_q + 1'b1 : init_refs_q;
    ref_cnt_d   = ref_cnt_q + REF_CNT_W'(cbr_start);

    new_v = '0;
    new_v[RULE_RP]       = ras_fell && rose_seen_q && (ras_t < RW'(T_RP));
    new_v[RULE_RAS_MIN]  = ras_rose && (ras_t < RW'(T_RAS));
    new_v[RULE_RAS_MAX]  = !s_ras && !ras_fell && (ras_t >= ras_limit);
    new_v[RULE_CBR_LEAD] = cbr_start && (cas_lead < CW'(T_CSR));
    new_v[RULE_CBR_HOLD] = cbr_q && cas_rose && !s_ras && (ras_t < RW'(T_CHR));
    new_v[RULE_INIT]     = normal_cas && !first_q &&
                           ((init_refs_q < NW'(INIT_REFS)) || (init_t < IW'(T_INIT)));
    new_v[RULE_DENSITY]  = win_short;
    new_v[RULE_RCD]      = normal_cas && !hit_q && (ras_t < RW'(T_RCD));
    new_v[RULE_CAS_MIN]  = acc_q && cas_rose && (cas_t < CW'(T_CAS));
    new_v[RULE_LATE_WR]  = acc_q && !s_cas && we_fell;

    viol_d = (clr_i ? '0 : viol_q) | new_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cbr_q       <= 1'b0;
      acc_q       <= 1'b0;
      hit_q       <= 1'b0;
      page_q      <= 1'b0;
      rose_seen_q <= 1'b0;
      first_q     <= 1'b0;
      init_refs_q <= '0;
      ref_cnt_q   <= '0;
      viol_q      <= '0;
    end else begin
      cbr_q       <= cbr_d;
      acc_q       <= acc_d;
      hit_q       <= hit_d;
      page_q      <= page_d;
      rose_seen_q <= rose_seen_d;
      first_q     <= first_d;
      init_refs_q <= init_refs_d;
      ref_cnt_q   <= ref_cnt_d;
      viol_q      <= viol_d;
    end
  end

  assign viol_o          = viol_q;
  assign refresh_count_o = ref_cnt_q;

  // R11
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((viol_q & $past(viol_q)) == $past(viol_q)));
  // R4
  ref_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ref_cnt_q) |-> (ref_cnt_q == REF_CNT_W'($past(ref_cnt_q) + 1'b1)));
  // R5
  cbr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cbr_q && !ras_rose) |-> !s_ras);
  // R9
  acc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q && !cas_rose) |-> !s_cas);
  // R6
  first_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    first_q |=> first_q);
endmodule

// File: tb/dram_strobe_monitor_bench.sv
module dram_strobe_monitor_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [9:0] IGN_DENS = 10'h040;

  logic clk, rst_n, clr, ras_n, cas_n, we_n;
  logic [9:0]  viol;
  logic [15:0] rcount;
  int n_vec, n_bad, tick, t0;

  dram_strobe_monitor #(
    .T_RP(4), .T_RAS(6), .T_RAS_MAX(40), .T_RASP_MAX(80), .T_CSR(2), .T_CHR(3),
    .T_RCD(3), .T_CAS(2), .T_INIT(100), .INIT_REFS(2), .REF_WINDOW(400),
    .REF_MIN(3), .REF_CNT_W(16)
  ) u_dram_strobe_monitor (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .ras_n_i(ras_n), .cas_n_i(cas_n),
    .we_n_i(we_n), .viol_o(viol), .refresh_count_o(rcount)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) tick <= tick + 1;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic chk_v(input string req, input logic [9:0] exp);
    check(req, 32'(viol & ~IGN_DENS), 32'(exp));
  endtask

  task automatic do_reset();
    rst_n = 1'b0; clr = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    step(3);
    rst_n = 1'b1;
    t0 = tick;
    step(2);
  endtask

  task automatic clear();
    clr = 1'b1; step(1); clr = 1'b0; step(1);
  endtask

  // wmode: 0 read, 1 early write, 2 late write
  task automatic access(input int rcd, input int cl, input int tail, input int wmode);
    ras_n = 1'b0;
    if (wmode == 1) we_n = 1'b0;
    step(rcd);
    cas_n = 1'b0;
    if (wmode == 2) begin step(1); we_n = 1'b0; step(cl - 1); end
    else step(cl);
    cas_n = 1'b1; step(tail);
    ras_n = 1'b1; we_n = 1'b1; step(8);
  endtask

  task automatic ras_only(input int l);
    ras_n = 1'b0; step(l); ras_n = 1'b1; step(8);
  endtask

  task automatic cbr(input int lead, input int hold);
    cas_n = 1'b0; step(lead);
    ras_n = 1'b0; step(hold);
    cas_n = 1'b1; step(8);
    ras_n = 1'b1; step(8);
  endtask

  task automatic page(input int total);
    ras_n = 1'b0; step(4);
    cas_n = 1'b0; step(3); cas_n = 1'b1; step(3);
    cas_n = 1'b0; step(3); cas_n = 1'b1;
    step(total - 13);
    ras_n = 1'b1; step(8);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int c0;
    n_vec = 0; n_bad = 0; tick = 0;
    do_reset();
    check("R1 flags", 32'(viol), 32'h0);
    check("R1 count", 32'(rcount), 32'h0);

    // R6: access straight after reset
    step(5); access(4, 3, 3, 0);
    chk_v("R6 early access", 10'h020);
    // R6: enough delay, too few refreshes
    do_reset(); cbr(3, 4);
    while (tick - t0 < 120) step(1);
    access(4, 3, 3, 0);
    chk_v("R6 one refresh", 10'h020);
    // R6: enough refreshes, too little delay
    do_reset(); cbr(3, 4); cbr(3, 4);
    access(4, 3, 3, 0);
    chk_v("R6 short delay", 10'h020);
    // R6 satisfied; R4 counting
    do_reset(); cbr(3, 4); cbr(3, 4);
    check("R4 two refreshes", 32'(rcount), 32'd2);
    while (tick - t0 < 120) step(1);
    access(4, 3, 3, 0);
    chk_v("R6 proper init", 10'h000);
    check("R4 access no count", 32'(rcount), 32'd2);
    ras_only(10);
    check("R4 row-only no count", 32'(rcount), 32'd2);

    // R2 sweep of row-strobe high time
    for (int h = 2; h <= 5; h++) begin
      clear();
      ras_n = 1'b0; step(8); ras_n = 1'b1; step(h); ras_n = 1'b0; step(8); ras_n = 1'b1; step(8);
      chk_v("R2 precharge", (h < 4) ? 10'h001 : 10'h000);
    end
    // R3 short low sweep
    for (int l = 3; l <= 8; l++) begin
      clear(); ras_only(l);
      chk_v("R3 low short", (l < 6) ? 10'h002 : 10'h000);
    end
    // R3 long low, non-page and page
    for (int l = 40; l <= 41; l++) begin
      clear(); ras_only(l);
      chk_v("R3 low long", (l > 40) ? 10'h004 : 10'h000);
    end
    clear(); page(60); chk_v("R3 page within", 10'h000);
    clear(); page(81); chk_v("R3 page over", 10'h004);

    // R5 lead sweep (also R4 count step)
    for (int ld = 0; ld <= 3; ld++) begin
      clear(); c0 = int'(rcount);
      cbr(ld, 4);
      chk_v("R5 lead", (ld < 2) ? 10'h008 : 10'h000);
      check("R4 refresh step", 32'(rcount), 32'(c0 + 1));
    end
    for (int hd = 1; hd <= 4; hd++) begin
      clear(); cbr(3, hd);
      chk_v("R5 hold", (hd < 3) ? 10'h010 : 10'h000);
    end
    // R8 sweep
    for (int d = 1; d <= 4; d++) begin
      clear(); access(d, 3, 3, 0);
      chk_v("R8 row-to-column", (d < 3) ? 10'h080 : 10'h000);
    end
    // R9 sweep
    for (int c = 1; c <= 3; c++) begin
      clear(); access(4, c, 3, 0);
      chk_v("R9 column pulse", (c < 2) ? 10'h100 : 10'h000);
    end
    // R10 write modes
    for (int w = 0; w <= 2; w++) begin
      clear(); access(4, 3, 3, w);
      chk_v("R10 write order", (w == 2) ? 10'h200 : 10'h000);
    end
    // R11 sticky then clear
    clear(); ras_only(3); step(20);
    chk_v("R11 held", 10'h002);
    clear(); chk_v("R11 cleared", 10'h000);

    // R7 density windows
    do_reset();
    cbr(3, 4); cbr(3, 4); cbr(3, 4);
    while (tick - t0 < 420) step(1);
    check("R7 full window", 32'(viol), 32'h0);
    cbr(3, 4); cbr(3, 4);
    while (tick - t0 < 820) step(1);
    check("R7 short window", 32'(viol), 32'h040);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule